// File: doc/BRIEF.md
# Hot-Plug Pulse Classifier with Event Queue

This block watches one already-synchronized hot-plug line from a display sink. It turns the line's level changes into three kinds of event: the sink being attached, the sink being removed, and a short low-going interrupt pulse sent by an attached sink. Four thresholds set the classification. Each is measured in ticks of an external timebase strobe, so the same logic works with any tick rate.

Each classified event is appended to a four-deep queue of 2-bit codes. The whole queue is visible at once as one packed 8-bit word, so a single register read returns every pending event in arrival order. A pop strobe retires the oldest entry and a flush strobe empties the queue. A reset-state strobe forces the connection tracker back to "detached". An interrupt output stays high while anything is queued.

Top module: `hpd_pulse_classifier`

## Requirements
- R1: After `rst_ni` is released, `queue_o` is 0, `count_o` is 0, `connected_o` is 0, `overflow_o` is 0 and `event_irq_o` is 0.
- R2: While detached, once the line has been high for at least `stable_hi_i` ticks, the attach code 2'b10 is queued and `connected_o` goes to 1. With fewer ticks, nothing is queued.
- R3: While attached, once the line has been low for at least `stable_lo_i` ticks, the detach code 2'b01 is queued and `connected_o` goes to 0.
- R4: While attached, a low period of w ticks that ends with a rise queues the pulse code 2'b11 when `irq_min_i` <= w <= `irq_max_i`. `connected_o` stays at 1.
- R5: While attached, a low period shorter than `irq_min_i` ticks, or longer than `irq_max_i` but shorter than `stable_lo_i` ticks, queues nothing and leaves `connected_o` at 1.
- R6: The oldest entry sits in `queue_o[1:0]`, the next in [3:2], then [5:4] and [7:6]. Fields at positions at or above `count_o` read 2'b00. `count_o` never exceeds 4.
- R7: `pop_i` removes the oldest entry and shifts each remaining entry down by one field. A pop on an empty queue has no effect.
- R8: An event that arrives while four entries are held and no pop is present is dropped, and `overflow_o` goes high. It stays high until a flush or a reset.
- R9: `flush_i` empties the queue and clears `overflow_o` on the next edge. An event that arrives in the same cycle as the flush is discarded.
- R10: While `reset_state_i` is high, `connected_o` is 0 and no event is queued. After release, the tracker re-evaluates from the detached state.
- R11: `event_irq_o` is high exactly when `count_o` is nonzero.
- R12: No pulse code is queued while detached, and no attach code is queued while already attached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe; one tick per high cycle |
| hpd_i | input | 1 | Synchronized hot-plug line |
| irq_min_i | input | 12 | Shortest low width, in ticks, accepted as a pulse |
| irq_max_i | input | 12 | Longest low width, in ticks, accepted as a pulse |
| stable_hi_i | input | 12 | High time, in ticks, needed to attach |
| stable_lo_i | input | 12 | Low time, in ticks, needed to detach |
| flush_i | input | 1 | Empties the queue |
| reset_state_i | input | 1 | Holds the tracker detached |
| pop_i | input | 1 | Retires the oldest queue entry |
| queue_o | output | 8 | Packed event codes, oldest in the low field |
| count_o | output | 3 | Number of queued events (0..4) |
| connected_o | output | 1 | Tracked attach state |
| overflow_o | output | 1 | Sticky flag: an event was dropped |
| event_irq_o | output | 1 | High while the queue is not empty |

## Verification
A wrong width count or a wrong attach state shows up at the ports no later than the first rise that ends a low period. It appears as a missing or extra 2'b11, or as an attach or detach code queued one segment early or late. Corruption in the queue shows in `queue_o` on the edge after the push or pop that caused it: a misplaced field, a nonzero vacant field, or a count that no longer matches. A lost overflow flag or a stale overflow flag is visible as soon as the fifth event arrives or a flush is issued.

// File: rtl/hpd_cls_pkg.sv
package hpd_cls_pkg;
  localparam int unsigned EV_W = 2;

  typedef enum logic [EV_W-1:0] {
    EV_NONE   = 2'b00,
    EV_UNPLUG = 2'b01,
    EV_PLUG   = 2'b10,
    EV_IRQ    = 2'b11
  } hpd_ev_e;
endpackage

// File: rtl/hpd_level_tracker.sv
module hpd_level_tracker
  import hpd_cls_pkg::*;
#(
  parameter int unsigned TICK_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hpd_i,
  input  logic [TICK_W-1:0] irq_min_i,
  input  logic [TICK_W-1:0] irq_max_i,
  input  logic [TICK_W-1:0] stable_hi_i,
  input  logic [TICK_W-1:0] stable_lo_i,
  input  logic              reset_state_i,
  output logic              ev_valid_o,
  output hpd_ev_e           ev_code_o,
  output logic              connected_o
);
  logic              lvl_q;
  logic              conn_q, conn_d;
  logic [TICK_W-1:0] run_q;
  logic              chg, rise, run_sat;

  assign chg     = hpd_i != lvl_q;
  assign rise    = chg & hpd_i;
  assign run_sat = &run_q;

  // run_q: ticks spent at the current level, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (chg) begin
      lvl_q <= hpd_i;
      run_q <= '0;
    end else if (tick_i && !run_sat) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_comb begin
    ev_valid_o = 1'b0;
    ev_code_o  = EV_NONE;
    conn_d     = conn_q;
    if (reset_state_i) begin
      conn_d = 1'b0;
    end else if (rise) begin
      if (conn_q && run_q >= irq_min_i && run_q <= irq_max_i) begin
        ev_valid_o = 1'b1;
        ev_code_o  = EV_IRQ;
      end
    end else if (!chg) begin
      if (lvl_q && !conn_q && run_q >= stable_hi_i) begin
        ev_valid_o = 1'b1;
        ev_code_o  = EV_PLUG;
        conn_d     = 1'b1;
      end else if (!lvl_q && conn_q && run_q >= stable_lo_i) begin
        ev_valid_o = 1'b1;
        ev_code_o  = EV_UNPLUG;
        conn_d     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conn_q <= 1'b0;
    else         conn_q <= conn_d;
  end

  assign connected_o = conn_q;

  a_r10_reset_state_disconnects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_state_i |=> !connected_o);

  a_r2_plug_after_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conn_q) |-> ($past(lvl_q) && $past(run_q) >= $past(stable_hi_i)));

  a_r3_unplug_after_stable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conn_q) |-> ($past(reset_state_i) ||
                       (!$past(lvl_q) && $past(run_q) >= $past(stable_lo_i))));
endmodule

// File: rtl/hpd_evt_queue.sv
module hpd_evt_queue
  import hpd_cls_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  hpd_ev_e                  code_i,
  input  logic                     pop_i,
  input  logic                     flush_i,
  output logic [DEPTH*EV_W-1:0]    word_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                     overflow_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [EV_W-1:0] ent_q [DEPTH];
  logic [EV_W-1:0] ent_d [DEPTH];
  logic [CW-1:0]   cnt_q, cnt_p, cnt_d;
  logic            ovf_q;
  logic            do_pop, full, accept;

  assign do_pop = pop_i && (cnt_q != '0);
  assign full   = cnt_q == CW'(DEPTH);
  assign accept = push_i && (!full || do_pop);
  assign cnt_p  = cnt_q - CW'(do_pop);
  assign cnt_d  = cnt_p + CW'(accept);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EV_W-1:0] shifted;
    if (i + 1 < DEPTH) begin : g_mid
      assign shifted = do_pop ? ent_q[i+1] : ent_q[i];
    end else begin : g_top
      assign shifted = do_pop ? EV_NONE : ent_q[i];
    end
    assign ent_d[i] = (accept && cnt_p == CW'(i)) ? code_i : shifted;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q[i] <= EV_NONE;
      else if (flush_i) ent_q[i] <= EV_NONE;
      else              ent_q[i] <= ent_d[i];
    end

    assign word_o[i*EV_W +: EV_W] = ent_q[i];

    a_r6_vacant_field_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CW'(i) >= cnt_q) |-> (ent_q[i] == EV_NONE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_q | (push_i && !accept);
    end
  end

  assign count_o    = cnt_q;
  assign overflow_o = ovf_q;

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  a_r8_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=>
      (overflow_o && count_o == CW'(DEPTH) && word_o == $past(word_o)));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0 && word_o == '0 && !overflow_o));

  a_r7_pop_shifts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q > 1 && !push_i && !flush_i) |=>
      (ent_q[0] == $past(ent_q[1]) && count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/hpd_pulse_classifier.sv
module hpd_pulse_classifier
  import hpd_cls_pkg::*;
#(
  parameter int unsigned TICK_W = 12,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          hpd_i,
  input  logic [TICK_W-1:0]             irq_min_i,
  input  logic [TICK_W-1:0]             irq_max_i,
  input  logic [TICK_W-1:0]             stable_hi_i,
  input  logic [TICK_W-1:0]             stable_lo_i,
  input  logic                          flush_i,
  input  logic                          reset_state_i,
  input  logic                          pop_i,
  output logic [DEPTH*EV_W-1:0]         queue_o,
  output logic [$clog2(DEPTH+1)-1:0]    count_o,
  output logic                          connected_o,
  output logic                          overflow_o,
  output logic                          event_irq_o
);
  logic    ev_valid;
  hpd_ev_e ev_code;

  hpd_level_tracker #(.TICK_W(TICK_W)) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .hpd_i         (hpd_i),
    .irq_min_i     (irq_min_i),
    .irq_max_i     (irq_max_i),
    .stable_hi_i   (stable_hi_i),
    .stable_lo_i   (stable_lo_i),
    .reset_state_i (reset_state_i),
    .ev_valid_o    (ev_valid),
    .ev_code_o     (ev_code),
    .connected_o   (connected_o)
  );

  hpd_evt_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ev_valid),
    .code_i     (ev_code),
    .pop_i      (pop_i),
    .flush_i    (flush_i),
    .word_o     (queue_o),
    .count_o    (count_o),
    .overflow_o (overflow_o)
  );

  assign event_irq_o = |count_o;

  a_r12_irq_only_when_connected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid && ev_code == EV_IRQ) |-> connected_o);
endmodule

// File: tb/hpd_pulse_classifier_test.sv
module hpd_pulse_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, hpd, flush, rs, pop;
  logic [11:0] t_min, t_max, t_hi, t_lo;
  logic [7:0]  queue;
  logic [2:0]  count;
  logic        conn, ovf, irq;

  always #4 clk = ~clk;

  hpd_pulse_classifier uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hpd_i(hpd),
    .irq_min_i(t_min), .irq_max_i(t_max), .stable_hi_i(t_hi), .stable_lo_i(t_lo),
    .flush_i(flush), .reset_state_i(rs), .pop_i(pop),
    .queue_o(queue), .count_o(count), .connected_o(conn),
    .overflow_o(ovf), .event_irq_o(irq)
  );

  int n_vec = 0, n_bad = 0;
  int m_q[4];
  int m_n = 0;
  bit m_ovf = 0, m_conn = 0, m_lvl = 0;
  int m_run = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_word();
    int w = 0;
    for (int i = 0; i < 4; i++) if (i < m_n) w |= (m_q[i] & 3) << (2 * i);
    return w;
  endfunction

  task automatic cmp_all(string tag);
    chk({tag, " R6 queue word"}, queue, exp_word());
    chk({tag, " R6 count"}, count, m_n);
    chk({tag, " R2/R3 connected"}, conn, m_conn);
    chk({tag, " R8 overflow"}, ovf, m_ovf);
    chk({tag, " R11 irq"}, irq, m_n != 0);
  endtask

  task automatic m_push(int code);
    if (m_n == 4) m_ovf = 1;
    else begin m_q[m_n] = code; m_n++; end
  endtask

  task automatic m_pop();
    if (m_n > 0) begin
      for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
      m_n--;
    end
  endtask

  task automatic m_eval();
    if (m_lvl && !m_conn && m_run >= t_hi) begin m_push(2); m_conn = 1; end
    else if (!m_lvl && m_conn && m_run >= t_lo) begin m_push(1); m_conn = 0; end
  endtask

  task automatic step(bit t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic seg(bit lvl, int n);
    if (lvl != m_lvl) begin
      if (lvl && m_conn && m_run >= t_min && m_run <= t_max) m_push(3);
      hpd = lvl; m_lvl = lvl; m_run = 0;
      step(0);
    end
    for (int k = 0; k < n; k++) begin
      step(1); step(0);
      if (m_run < 4095) m_run++;
    end
    m_eval();
    step(0); step(0);
  endtask

  task automatic do_pop();
    pop = 1; step(0); pop = 0; m_pop(); step(0);
  endtask

  task automatic do_flush();
    flush = 1; step(0); flush = 0; m_n = 0; m_ovf = 0;
    for (int i = 0; i < 4; i++) m_q[i] = 0;
    step(0);
  endtask

  task automatic do_rs(string tag);
    rs = 1; step(0); step(0);
    chk({tag, " R10 held disconnected"}, conn, 0);
    chk({tag, " R10 no event"}, count, m_n);
    rs = 0; m_conn = 0;
    m_eval();
    step(0); step(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    rst_n = 0; tick = 0; hpd = 0; flush = 0; rs = 1; pop = 0;
    t_min = 3; t_max = 8; t_lo = 12; t_hi = 10;
    for (int i = 0; i < 4; i++) m_q[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0);
    cmp_all("R1 reset");
    rs = 0; step(0);

    seg(1, 9);  cmp_all("R2 high one tick short");
    seg(1, 1);  cmp_all("R2 plug at stable_hi");
    seg(0, 2);  seg(1, 1); cmp_all("R5 glitch below min");
    seg(0, 3);  seg(1, 1); cmp_all("R4 pulse at min");
    seg(0, 8);  seg(1, 1); cmp_all("R4 pulse at max");
    seg(0, 9);  seg(1, 1); cmp_all("R5 above max");
    seg(0, 11); seg(1, 1); cmp_all("R5 just below stable_lo");
    seg(0, 12); cmp_all("R3 unplug at stable_lo");
    seg(1, 1);  seg(0, 4); seg(1, 1); cmp_all("R12 pulse while detached");
    seg(1, 9);  cmp_all("R8 plug into full queue");
    do_pop();   cmp_all("R7 pop one");
    do_pop();   cmp_all("R7 pop two");
    do_pop(); do_pop(); cmp_all("R7 pop to empty");
    do_pop();   cmp_all("R7 pop on empty");
    seg(1, 30); cmp_all("R12 no second plug");
    seg(0, 5);  seg(1, 1); cmp_all("R4 pulse before flush");
    do_flush(); cmp_all("R9 flush");
    do_rs("R10 high level");
    cmp_all("R10 replug after release");
    seg(0, 20); cmp_all("R3 unplug again");
    do_rs("R10 low level");
    cmp_all("R10 after release low");

    t_min = 2; t_max = 6; t_lo = 9; t_hi = 7;
    m_eval(); step(0); step(0);
    for (int s = 0; s < 400; s++) begin
      int r = $urandom_range(0, 99);
      if (r < 25) do_pop();
      else if (r < 29) do_flush();
      else if (r < 32) do_rs("R10 random");
      seg(!m_lvl, $urandom_range(0, 13));
      cmp_all("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule